// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a watchdog timer that counts pulses of a slow tick, delivered as a single-cycle enable in the system clock domain. A 3-bit period code picks one of eight time-outs. Code 0 is the shortest, and each higher code doubles the length. Software restarts the count with a kick strobe. If the selected period elapses with no kick, the block emits a reset request one system clock wide and starts counting again from zero.

Configuration arrives on a write strobe that carries three values: an enable bit, a change bit and a period code. The static safety input selects how strict the block is.

- **Level low:** the watchdog starts disabled, and a plain write with the enable bit set turns it on.
- **Level high:** the watchdog starts enabled and can never be turned off.

In both levels, turning the watchdog off or changing its period only takes effect through an unlock. The unlock is a write with both the change bit and the enable bit set. It opens a short window of system clocks, and the single write that follows inside that window is applied.

Top module: `wdog_guard`

## Requirements
- R1: On reset the period code is 0; the watchdog is disabled when `lvl_hi` is 0 and enabled when `lvl_hi` is 1.
- R2: A write without the change bit sets the watchdog enabled when its enable bit is 1; it never disables the watchdog and never alters the period code.
- R3: A write with both the change bit and the enable bit set (the unlock write) enables the watchdog and opens a window of WIN_LEN (default 4) system clocks. A write in any of the WIN_LEN cycles that follow the unlock cycle loads the period code from its period field and the enable from its enable bit.
- R4: The window closes at the first write inside it, so a second write leaves enable and period unchanged.
- R5: A write made WIN_LEN+1 or more cycles after the unlock cycle, with no new unlock, leaves enable and period unchanged.
- R6: With `lvl_hi` = 1 the watchdog stays enabled through any write, including a write inside an open window; period changes through the window still apply.
- R7: The period for code n is 2^(BASE_LOG2+n) ticks. `wd_rst_req` rises in the cycle after the tick that completes the period counted from the last restart, and stays high for exactly one cycle.
- R8: A kick restarts the count from zero, and a kick in the same cycle as the completing tick suppresses that reset request.
- R9: Only cycles with `slow_tick` = 1 advance the count.
- R10: While the watchdog is disabled the count is held at zero, so after re-enabling a full period elapses before a reset request.
- R11: After a reset request the count restarts from zero, and the next request comes after another full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slow_tick | input | 1 | Single-cycle enable marking one slow-oscillator tick |
| lvl_hi | input | 1 | Static safety level: 0 = may be disabled, 1 = always enabled |
| wr_vld | input | 1 | Configuration write strobe |
| wr_en_bit | input | 1 | Enable bit of the write |
| wr_chg_bit | input | 1 | Change bit of the write (unlock when set together with the enable bit) |
| wr_sel | input | 3 | Period code of the write |
| kick | input | 1 | Restart strobe for the count |
| wd_on | output | 1 | Current enable state |
| wd_sel | output | 3 | Current period code |
| wd_rst_req | output | 1 | One-cycle reset request on time-out |

## Verification
The embedded properties check the following on every cycle:
- A period change never happens without an open window.
- The enable only falls after an open window, and only at the low level.
- The window never runs past its length and shuts after a write.
- The reset request is one cycle wide and only follows an enabled cycle.
- A disabled or kicked counter does not fire.

The directed scenarios show the things no single-cycle property can express:
- the exact tick count to each time-out for several period codes and tick spacings;
- the last cycle at which the window still accepts a write;
- the kick that beats the completing tick;
- the full period after re-enabling or after a request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // width of the period code field
  parameter int unsigned PSEL_W = 3;

  // one configuration write as seen by the control logic
  typedef struct packed {
    logic              en_bit;
    logic              chg_bit;
    logic [PSEL_W-1:0] per;
  } cfg_wr_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int unsigned WIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_hi,
  input  logic              wr_vld,
  input  cfg_wr_t           wr,
  output logic              en_o,
  output logic [PSEL_W-1:0] sel_o
);

  localparam int unsigned WC_W = $clog2(WIN_LEN + 1);

  logic              en_q,  en_d;
  logic [PSEL_W-1:0] sel_q, sel_d;
  logic [WC_W-1:0]   win_q, win_d;
  logic              win_open;

  assign win_open = (win_q != '0);

  // next-state logic
  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    win_d = win_open ? (win_q - WC_W'(1)) : win_q;
    if (wr_vld) begin
      if (win_open) begin
        // the one protected write the window admits
        sel_d = wr.per;
        en_d  = wr.en_bit;
        win_d = '0;
      end else if (wr.chg_bit && wr.en_bit) begin
        // unlock: enabling is always allowed, window opens
        en_d  = 1'b1;
        win_d = WC_W'(WIN_LEN);
      end else if (wr.en_bit) begin
        en_d  = 1'b1;
      end
    end
    if (lvl_hi) begin
      en_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= lvl_hi;
      sel_q <= '0;
      win_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
      win_q <= win_d;
    end
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  // R3
  sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(win_open));

  // R6
  lvl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hi |-> en_q);

  // R5
  off_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(win_open) && !lvl_hi));

  // R4
  win_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && win_open) |=> !win_open);

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WC_W'(WIN_LEN));

endmodule

// File: rtl/wdog_lim.sv
module wdog_lim #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 11,
  parameter int unsigned CNT_W     = 18
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] lim
);

  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] tab [NSEL];

  // last count value of each period: 2^(BASE_LOG2+i) - 1
  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    assign tab[i] = CNT_W'((64'd1 << (BASE_LOG2 + i)) - 64'd1);
  end

  assign lim = tab[sel];

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  // next-state logic: disable and kick hold the count at zero
  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!en || clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // R7 (every period is at least two ticks, so pulses cannot touch)
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R7
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(en));

  // R8
  kick_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req_q);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !req_q);

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> $stable(cnt_q) && !req_q);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 11,
  parameter int unsigned WIN_LEN   = 4,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              lvl_hi,
  input  logic              wr_vld,
  input  logic              wr_en_bit,
  input  logic              wr_chg_bit,
  input  logic [PSEL_W-1:0] wr_sel,
  input  logic              kick,
  output logic              wd_on,
  output logic [PSEL_W-1:0] wd_sel,
  output logic              wd_rst_req
);

  localparam int unsigned NSEL  = 1 << PSEL_W;
  localparam int unsigned CNT_W = BASE_LOG2 + NSEL - 1;

  logic             srst_n;
  cfg_wr_t          wr_word;
  logic             en_w;
  logic [PSEL_W-1:0] sel_w;
  logic [CNT_W-1:0] lim_w;

  assign wr_word = '{en_bit: wr_en_bit, chg_bit: wr_chg_bit, per: wr_sel};

  wdog_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  wdog_cfg #(.WIN_LEN(WIN_LEN)) u_cfg (
    .clk    (clk),
    .rst_n  (srst_n),
    .lvl_hi (lvl_hi),
    .wr_vld (wr_vld),
    .wr     (wr_word),
    .en_o   (en_w),
    .sel_o  (sel_w)
  );

  wdog_lim #(
    .SEL_W     (PSEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W)
  ) u_lim (
    .sel (sel_w),
    .lim (lim_w)
  );

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (en_w),
    .tick  (slow_tick),
    .clr   (kick),
    .lim   (lim_w),
    .req_o (wd_rst_req)
  );

  assign wd_on  = en_w;
  assign wd_sel = sel_w;

endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb_top;

  localparam int unsigned BASE = 4;

  logic       clk;
  logic       rst_n;
  logic       slow_tick;
  logic       lvl_hi;
  logic       wr_vld;
  logic       wr_en_bit;
  logic       wr_chg_bit;
  logic [2:0] wr_sel;
  logic       kick;
  logic       wd_on;
  logic [2:0] wd_sel;
  logic       wd_rst_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  wdog_guard #(.BASE_LOG2(BASE), .WIN_LEN(4), .SYNC_N(2)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_tick  (slow_tick),
    .lvl_hi     (lvl_hi),
    .wr_vld     (wr_vld),
    .wr_en_bit  (wr_en_bit),
    .wr_chg_bit (wr_chg_bit),
    .wr_sel     (wr_sel),
    .kick       (kick),
    .wd_on      (wd_on),
    .wd_sel     (wd_sel),
    .wd_rst_req (wd_rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 1'b0; lvl_hi = lvl;
    slow_tick = 0; wr_vld = 0; wr_en_bit = 0; wr_chg_bit = 0; wr_sel = 0; kick = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic wr(input logic e, input logic c, input logic [2:0] s);
    wr_vld = 1; wr_en_bit = e; wr_chg_bit = c; wr_sel = s;
    step();
    wr_vld = 0; wr_en_bit = 0; wr_chg_bit = 0; wr_sel = 0;
  endtask

  // ticks every 'gap' cycles; returns tick count at first request
  task automatic measure(input bit do_kick, input int gap, output int got);
    int n = 0;
    got = -1;
    if (do_kick) begin
      kick = 1; step(); kick = 0;
    end
    for (int c = 0; c < 20000; c++) begin
      slow_tick = ((c % gap) == (gap - 1));
      step();
      if (slow_tick) n++;
      slow_tick = 0;
      if (wd_rst_req) begin
        got = n;
        break;
      end
    end
    step();
    chk("R7 pulse width", int'(wd_rst_req), 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1; step(); slow_tick = 0;
      chk("R8 no early request", int'(wd_rst_req), 0);
    end
  endtask

  task automatic t_reset_l1();
    do_reset(0);
    chk("R1 disabled at reset", int'(wd_on), 0);
    chk("R1 period code zero", int'(wd_sel), 0);
    for (int i = 0; i < 40; i++) begin
      slow_tick = 1; step();
    end
    slow_tick = 0;
    chk("R10 no request while disabled", int'(wd_rst_req), 0);
  endtask

  task automatic t_plain();
    do_reset(0);
    wr(1, 0, 3'd5);
    chk("R2 plain enable", int'(wd_on), 1);
    chk("R2 plain keeps period", int'(wd_sel), 0);
    wr(0, 0, 3'd2);
    chk("R2 plain cannot disable", int'(wd_on), 1);
    chk("R2 plain keeps period again", int'(wd_sel), 0);
  endtask

  task automatic t_window_edge();
    do_reset(0);
    wr(1, 1, 3'd0);
    chk("R3 unlock enables", int'(wd_on), 1);
    repeat (3) step();
    wr(0, 0, 3'd3);
    chk("R3 last window cycle disables", int'(wd_on), 0);
    chk("R3 last window cycle loads period", int'(wd_sel), 3);
  endtask

  task automatic t_window_late();
    do_reset(0);
    wr(1, 1, 3'd0);
    repeat (4) step();
    wr(0, 0, 3'd4);
    chk("R5 late write keeps enable", int'(wd_on), 1);
    chk("R5 late write keeps period", int'(wd_sel), 0);
  endtask

  task automatic t_one_shot();
    do_reset(0);
    wr(1, 1, 3'd0);
    wr(1, 0, 3'd2);
    chk("R3 period loaded", int'(wd_sel), 2);
    wr(0, 0, 3'd6);
    chk("R4 second write keeps period", int'(wd_sel), 2);
    chk("R4 second write keeps enable", int'(wd_on), 1);
  endtask

  task automatic t_timeout();
    int got;
    do_reset(0);
    wr(1, 0, 3'd0);
    measure(1, 1, got);
    chk("R7 code 0 period", got, 16);
    measure(0, 1, got);
    chk("R11 full period after request", got, 16);
    wr(1, 1, 3'd0);
    wr(1, 0, 3'd2);
    measure(1, 1, got);
    chk("R7 code 2 period", got, 64);
  endtask

  task automatic t_tick_gap();
    int got;
    do_reset(0);
    wr(1, 0, 3'd0);
    measure(1, 3, got);
    chk("R9 spaced ticks", got, 16);
  endtask

  task automatic t_kick();
    int got;
    do_reset(0);
    wr(1, 0, 3'd0);
    kick = 1; step(); kick = 0;
    ticks(15);
    slow_tick = 1; kick = 1; step(); slow_tick = 0; kick = 0;
    chk("R8 kick beats completing tick", int'(wd_rst_req), 0);
    measure(0, 1, got);
    chk("R8 full period after kick", got, 16);
  endtask

  task automatic t_disable_restart();
    int got;
    do_reset(0);
    wr(1, 0, 3'd0);
    ticks(10);
    wr(1, 1, 3'd0);
    wr(0, 0, 3'd0);
    chk("R10 disabled through window", int'(wd_on), 0);
    wr(1, 0, 3'd0);
    measure(0, 1, got);
    chk("R10 full period after re-enable", got, 16);
  endtask

  task automatic t_level2();
    do_reset(1);
    chk("R1 level high starts enabled", int'(wd_on), 1);
    wr(0, 0, 3'd0);
    chk("R6 plain disable ignored", int'(wd_on), 1);
    wr(1, 1, 3'd0);
    wr(0, 0, 3'd1);
    chk("R6 window disable ignored", int'(wd_on), 1);
    chk("R6 window period applied", int'(wd_sel), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_l1();
    t_plain();
    t_window_edge();
    t_window_late();
    t_one_shot();
    t_timeout();
    t_tick_gap();
    t_kick();
    t_disable_restart();
    t_level2();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule